// File: doc/BRIEF.md
# Byte Clock Phase Alignment Monitor

This block sits on the fast serial bit clock of a transmit path. It makes a local byte clock by counting bit periods, and it watches a byte clock that arrives from elsewhere. Both byte clocks have the same frequency, but the phase between them is arbitrary. The block brings the external byte clock into the bit clock domain through a two-flop synchroniser. It marks each rising edge of the external clock and records the local count at that moment as the measured phase.

When the measured phase puts the two byte clock edges less than one bit period apart, a byte transfer between the domains would have too little setup or hold margin. The block then raises an alignment event. If the sync request is high at that moment, the block also moves its local byte clock by half a byte period, which inverts it. Each inversion spoils one byte. The request is therefore meant to stay low except while a correction is wanted. After an inversion, a hold-off window blocks a second one until the new phase has been measured again.

Top module: `byte_phase_monitor`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the count returns to 0. `intByteClk` is then 1 and `measPhase` and `alignEvent` are 0.
- R2: A 3-bit count advances by one on every bit clock edge. `intByteClk` is 1 while the count is 0 to 3 and 0 while it is 4 to 7, so the internal byte clock has a period of eight bit clocks.
- R3: Let c be the count after the first bit clock edge that samples `extByteClk` high after a low sample. Two edges later, `measPhase` takes the value (c+1) mod 8 and holds it until the next such rising edge has been processed.
- R4: When `measPhase` is loaded, `alignEvent` is loaded with 1 if the measured phase is 7, 0 or 1 (an unsafe phase) and with 0 otherwise. It keeps that value until the next measurement, so it stays high for as long as unsafe measurements continue.
- R5: On the edge that loads an unsafe measurement, the count advances by 5 instead of 1 if `syncReq` is high on that edge and no hold-off is running. This shifts the internal byte clock by four bit periods.
- R6: `syncReq` has no effect on an edge that loads no measurement, or on an edge whose measurement is safe.
- R7: After an inversion on edge n, no inversion takes place on edges n+1 to n+15. An inversion is allowed again from edge n+16, which is two byte periods later.
- R8: With a steady external clock at an unsafe phase and `syncReq` held high, exactly one inversion occurs. The next measurement is the old phase plus 4 (mod 8), and `alignEvent` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| extByteClk | input | 1 | Byte clock from the other timing domain, asynchronous to `clk` |
| syncReq | input | 1 | Allows an inversion of the internal byte clock when the phase is unsafe |
| intByteClk | output | 1 | Internal byte clock, derived from the bit count |
| measPhase | output | 3 | Count value recorded at the latest external rising edge, as defined in R3 |
| alignEvent | output | 1 | High while the latest measurement was unsafe |

## Verification
Loading the measurement, with its alignment event, and inverting the byte clock can both happen on the same bit clock edge. The inversion is chosen from the same unsafe measurement that is being loaded. The bench provokes this by sweeping every external phase with the sync request held high and with it toggling. An external clock that rises every four bit periods keeps landing in the unsafe window straight after a correction, which exercises the hold-off. For each case, the count, the phase and the event are judged against the measurement computed from the requirement arithmetic. The internal clock must move only on the edge that loads an unsafe phase, and never inside the hold-off window.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic capture;   // load the measured phase this edge
    logic invert;    // shift the byte counter by half a byte
  } bpmStrobe_t;

endpackage

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BYTE_BITS),
  localparam int HALF       = BYTE_BITS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extByteClk,
  input  bpmStrobe_t       strobe,
  output logic             extRise,
  output logic [CNT_W-1:0] cntNow,
  output logic [CNT_W-1:0] measPhase,
  output logic             intByteClk
);

  // synchroniser stages plus one extra flop for edge detection
  logic [SYNC_STAGES:0] syncChain;

  generate
    for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[s] <= 1'b0;
          else     syncChain[s] <= extByteClk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[s] <= 1'b0;
          else     syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign extRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  // byte counter: normal step is one, an inversion adds half a byte
  logic [CNT_W-1:0] cntStep;
  assign cntStep = strobe.invert ? CNT_W'(HALF + 1) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) cntNow <= '0;
    else     cntNow <= cntNow + cntStep;
  end

  assign intByteClk = (cntNow < CNT_W'(HALF));

  // measured phase register
  always_ff @(posedge clk) begin
    if (rst)                 measPhase <= '0;
    else if (strobe.capture) measPhase <= cntNow;
  end

  logic capStb;
  assign capStb = strobe.capture;

  // R2: the counter only ever takes the normal step or the inverting step
  a_r2_counter_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cntNow == CNT_W'($past(cntNow) + 1) ||
                     cntNow == CNT_W'($past(cntNow) + HALF + 1)));

  // R3: the phase is held between captures
  a_r3_phase_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(capStb)) |-> $stable(measPhase));

endmodule

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
#(
  parameter int BYTE_BITS     = 8,
  parameter int GUARD_AFTER   = 1,
  parameter int GUARD_BEFORE  = 1,
  parameter int HOLDOFF_BYTES = 2,
  localparam int CNT_W        = $clog2(BYTE_BITS),
  localparam int HOLD_CYC     = HOLDOFF_BYTES * BYTE_BITS,
  localparam int HOLD_W       = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extRise,
  input  logic [CNT_W-1:0] cntNow,
  input  logic             syncReq,
  output bpmStrobe_t       strobe,
  output logic             alignEvent
);

  // unsafe window, one flag per counter value
  logic [BYTE_BITS-1:0] winMask;

  generate
    for (genvar g = 0; g < BYTE_BITS; g++) begin : g_win
      assign winMask[g] = (g <= GUARD_AFTER) || (g >= BYTE_BITS - GUARD_BEFORE);
    end
  endgenerate

  logic unsafeNow;
  assign unsafeNow = winMask[cntNow];

  // hold-off after an inversion
  logic [HOLD_W-1:0] holdCnt;
  logic              holdClear;
  assign holdClear = (holdCnt == '0);

  always_comb begin
    strobe.capture = extRise;
    strobe.invert  = extRise & unsafeNow & syncReq & holdClear;
  end

  always_ff @(posedge clk) begin
    if (rst)                holdCnt <= '0;
    else if (strobe.invert) holdCnt <= HOLD_W'(HOLD_CYC - 1);
    else if (!holdClear)    holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          alignEvent <= 1'b0;
    else if (extRise) alignEvent <= unsafeNow;
  end

  // independent edge counter since the last inversion, for checking only
  logic [HOLD_W-1:0] sinceInv;
  always_ff @(posedge clk) begin
    if (rst)                                  sinceInv <= HOLD_W'(HOLD_CYC);
    else if (strobe.invert)                   sinceInv <= HOLD_W'(1);
    else if (sinceInv < HOLD_W'(HOLD_CYC))    sinceInv <= sinceInv + 1'b1;
  end

  // R7: no inversion inside the hold-off window
  a_r7_holdoff_window: assert property (@(posedge clk) disable iff (rst)
    strobe.invert |-> sinceInv >= HOLD_W'(HOLD_CYC));

  // R4: the event changes only on an edge that loads a measurement
  a_r4_event_on_capture: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && alignEvent != $past(alignEvent)) |-> $past(extRise));

endmodule

// File: rtl/byte_phase_monitor.sv
module byte_phase_monitor
  import bpm_pkg::*;
#(
  parameter int BYTE_BITS     = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int GUARD_AFTER   = 1,
  parameter int GUARD_BEFORE  = 1,
  parameter int HOLDOFF_BYTES = 2,
  localparam int CNT_W        = $clog2(BYTE_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extByteClk,
  input  logic             syncReq,
  output logic             intByteClk,
  output logic [CNT_W-1:0] measPhase,
  output logic             alignEvent
);

  bpmStrobe_t       strobe;
  logic             extRise;
  logic [CNT_W-1:0] cntNow;

  bpm_datapath #(
    .BYTE_BITS   (BYTE_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .extByteClk (extByteClk),
    .strobe     (strobe),
    .extRise    (extRise),
    .cntNow     (cntNow),
    .measPhase  (measPhase),
    .intByteClk (intByteClk)
  );

  bpm_ctrl #(
    .BYTE_BITS     (BYTE_BITS),
    .GUARD_AFTER   (GUARD_AFTER),
    .GUARD_BEFORE  (GUARD_BEFORE),
    .HOLDOFF_BYTES (HOLDOFF_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .extRise    (extRise),
    .cntNow     (cntNow),
    .syncReq    (syncReq),
    .strobe     (strobe),
    .alignEvent (alignEvent)
  );

  // R5: a counter jump other than the normal step needs the sync request
  a_r5_jump_needs_sync: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cntNow != CNT_W'($past(cntNow) + 1)) |-> $past(syncReq));

  // R1: state after a reset edge
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (cntNow == '0 && !alignEvent && measPhase == '0));

endmodule

// File: tb/byte_phase_monitor_bench.sv
`timescale 1ns/1ps
module byte_phase_monitor_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       extByteClk = 1'b0;
  logic       syncReq = 1'b0;
  logic       intByteClk;
  logic [2:0] measPhase;
  logic       alignEvent;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string scenTag = "R2";

  always #2.5 clk = ~clk;

  byte_phase_monitor u_byte_phase_monitor (
    .clk        (clk),
    .rst        (rst),
    .extByteClk (extByteClk),
    .syncReq    (syncReq),
    .intByteClk (intByteClk),
    .measPhase  (measPhase),
    .alignEvent (alignEvent)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isUnsafe(input int p);
    return (p == 7) || (p == 0) || (p == 1);
  endfunction

  // requirement model: count, measured phase, event, per bit clock edge
  int  mCnt = 0;
  int  mPhase = 0;
  bit  mEvent = 0;
  bit  h1 = 0, h2 = 0, h3 = 0;
  int  cyc = 0;
  int  lastInv = -1000;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (rst) begin
        mCnt = 0; mPhase = 0; mEvent = 0;
        h1 = 0; h2 = 0; h3 = 0;
        lastInv = -1000;
      end else begin
        bit cap, uns, inv;
        cap = h2 && !h3;
        uns = isUnsafe(mCnt);
        inv = cap && uns && syncReq && (cyc - lastInv >= 16);
        if (cap) begin
          mPhase = mCnt;
          mEvent = uns;
        end
        if (inv) begin
          mCnt = (mCnt + 5) % 8;
          lastInv = cyc;
        end else begin
          mCnt = (mCnt + 1) % 8;
        end
        h3 = h2; h2 = h1; h1 = extByteClk;
      end
      #1;
      if (!rst) begin
        chk({scenTag, " R2 intByteClk"}, int'(intByteClk), (mCnt < 4) ? 1 : 0);
        chk({scenTag, " R3 measPhase"}, int'(measPhase), mPhase);
        chk({scenTag, " R4 alignEvent"}, int'(alignEvent), int'(mEvent));
      end
    end
  end

  // syncMode: 0 low, 1 high, 2 high on every third cycle
  task automatic runPattern(input int off, input int per, input int hi,
                            input int syncMode, input int n);
    @(negedge clk);
    rst = 1'b1; extByteClk = 1'b0; syncReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 intByteClk in reset", int'(intByteClk), 1);
    chk("R1 measPhase in reset", int'(measPhase), 0);
    chk("R1 alignEvent in reset", int'(alignEvent), 0);
    rst = 1'b0;
    for (int k = 1; k <= n; k++) begin
      extByteClk = (((k + 8 * per - off) % per) < hi);
      syncReq = (syncMode == 1) ? 1'b1 : (syncMode == 2) ? ((k % 3) == 0) : 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // every phase, sync low: measurement and event only
    scenTag = "R3";
    for (int off = 0; off < 8; off++) begin
      runPattern(off, 8, 4, 0, 48);
      chk("R3 steady phase", int'(measPhase), (off + 1) % 8);
      chk("R4 steady event", int'(alignEvent), isUnsafe((off + 1) % 8) ? 1 : 0);
    end

    // every phase, sync high: single correction for unsafe phases
    scenTag = "R5";
    for (int off = 0; off < 8; off++) begin
      int p;
      p = (off + 1) % 8;
      runPattern(off, 8, 4, 1, 48);
      if (isUnsafe(p))
        chk("R5 R8 phase after inversion", int'(measPhase), (p + 4) % 8);
      else
        chk("R6 safe phase untouched", int'(measPhase), p);
      chk("R8 event cleared", int'(alignEvent), 0);
    end

    // sync toggling while captures come and go
    scenTag = "R6";
    for (int off = 0; off < 8; off++)
      runPattern(off, 8, 4, 2, 48);

    // fast external edges keep hitting the window: hold-off
    scenTag = "R7";
    for (int off = 0; off < 4; off++)
      runPattern(off, 4, 2, 1, 96);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule